// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block holds the micro-program counter of a microcoded stack processor and works out, every cycle, which control-store word runs next. The microword at the current address provides two fields: a 3-bit next-address mode and a branch target. Three other inputs come from the datapath: the ALU zero flag, the count of live local variables, and the opcode held in the instruction register. From these the block selects one of several sources: the sequential address, the branch target, an opcode dispatch entry, the fetch entry point, or a skip of variable length.

The variable skip serves the unrolled save and restore of local variables. A skip word is followed by MAXV single-variable steps. The skip jumps over the steps that belong to variables not in use, so that only the last `ucount` steps run. Opcode dispatch computes its entries arithmetically: each defined opcode owns a fixed-size slot of microcode. An undefined opcode lands on the trap routine. The trap mode sends control back to fetch and raises a one-cycle trap pulse. The control store is not part of the block; its word arrives on the `mode` and `target` ports.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low, `upc` is forced to the fetch address 0 and `trap_pulse` is 0. Both hold at the first clock edge after release until the sequencer steps.
- R2: Mode code 0 (step) and mode code 7 (reserved) load `upc` with `upc + 1`. The addition wraps modulo 256, so 255 steps to 0.
- R3: Mode code 1 loads `target` when `zflag` is 0. Otherwise it loads `upc + 1`.
- R4: Mode code 2 loads `target` when `zflag` is 1. Otherwise it loads `upc + 1`.
- R5: Mode code 3 loads `target` when `ucount` is 0. Otherwise it loads `upc + 1`.
- R6: Mode code 4 loads `upc + 1 + (MAXV - min(ucount, MAXV))`, with MAXV = 4. Examples: ucount 0 advances by 5, ucount 2 by 3, ucount 4 or more by 1.
- R7: Mode code 5 with an opcode below 24 loads `16 + 8 * opcode`.
- R8: Mode code 5 with an opcode of 24 or more loads the trap routine address 248.
- R9: Mode code 6 loads the fetch address 0. `trap_pulse` is 1 for the one cycle that follows a mode-6 cycle and is 0 after any other cycle.
- R10: Outside reset, `next_upc` always shows the value that `upc` takes at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Next-address mode field of the current microword |
| target | input | 8 | Branch-target field of the current microword |
| zflag | input | 1 | ALU zero flag |
| ucount | input | 3 | Live local-variable count |
| opcode | input | 5 | Opcode from the instruction register |
| upc | output | 8 | Current micro-address |
| next_upc | output | 8 | Micro-address selected for the next cycle |
| trap_pulse | output | 1 | One-cycle trap indication |

## Verification
Random microwords with all eight mode codes are mixed with random flag, count, opcode and target values. This shows that each mode uses only its own condition input, since the unused inputs change freely around it. Directed runs cover the skip with counts 0, 2, 4 and 7, which separates the full skip, a partial skip and the saturation above MAXV. Directed runs also cover dispatch at opcodes 0, 23, 24 and 31, which marks the edge between the slot arithmetic and the trap fallback. A jump to 255 followed by a step checks wraparound. A trap followed by a non-trap word confirms that the pulse lasts exactly one cycle. A reset asserted in the middle of a run confirms the return to fetch.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [2:0] {
    UM_STEP     = 3'd0,
    UM_JZ0      = 3'd1,
    UM_JZ1      = 3'd2,
    UM_JU0      = 3'd3,
    UM_SKIP     = 3'd4,
    UM_DISPATCH = 3'd5,
    UM_TRAP     = 3'd6,
    UM_RSVD     = 3'd7
  } umode_e;

  localparam int UMODE_W = 3;

endpackage

// File: rtl/useq_cond.sv
module useq_cond
  import useq_pkg::*;
#(
  parameter int UCNT_W = 3
) (
  input  logic [UMODE_W-1:0] mode,
  input  logic               zflag,
  input  logic [UCNT_W-1:0]  ucount,
  output logic               take_target
);

  umode_e mode_e;
  assign mode_e = umode_e'(mode);

  always_comb begin
    case (mode_e)
      UM_JZ0:  take_target = ~zflag;
      UM_JZ1:  take_target = zflag;
      UM_JU0:  take_target = (ucount == '0);
      default: take_target = 1'b0;
    endcase
  end

endmodule

// File: rtl/useq_skip.sv
module useq_skip #(
  parameter int UADDR_W = 8,
  parameter int UCNT_W  = 3,
  parameter int MAXV    = 4
) (
  input  logic [UCNT_W-1:0]  ucount,
  output logic [UADDR_W-1:0] skip_adv
);

  // steps to jump over, plus one to leave the skip word itself
  function automatic logic [UADDR_W-1:0] advance_of(input logic [UCNT_W-1:0] cnt);
    int live;
    live = (int'(cnt) > MAXV) ? MAXV : int'(cnt);
    return UADDR_W'(1 + MAXV - live);
  endfunction

  assign skip_adv = advance_of(ucount);

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
  parameter int UADDR_W   = 8,
  parameter int OPC_W     = 5,
  parameter int NUM_OPS   = 24,
  parameter int BASE      = 16,
  parameter int STRIDE    = 8,
  parameter int TRAP_ADDR = 248
) (
  input  logic [OPC_W-1:0]   opcode,
  output logic [UADDR_W-1:0] dispatch_addr,
  output logic               dispatch_undef
);

  localparam bit STRIDE_POW2 = ((STRIDE & (STRIDE - 1)) == 0);
  localparam int SHIFT       = (STRIDE > 1) ? $clog2(STRIDE) : 0;

  logic [UADDR_W-1:0] slot_offset;

  generate
    if (STRIDE_POW2) begin : g_shift
      assign slot_offset = UADDR_W'(opcode) << SHIFT;
    end else begin : g_mult
      assign slot_offset = UADDR_W'(int'(opcode) * STRIDE);
    end
  endgenerate

  assign dispatch_undef = (int'(opcode) >= NUM_OPS);
  assign dispatch_addr  = dispatch_undef ? UADDR_W'(TRAP_ADDR)
                                         : UADDR_W'(BASE) + slot_offset;

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int UADDR_W    = 8,
  parameter int OPC_W      = 5,
  parameter int UCNT_W     = 3,
  parameter int MAXV       = 4,
  parameter int FETCH_ADDR = 0,
  parameter int TRAP_ADDR  = 248,
  parameter int NUM_OPS    = 24,
  parameter int DISP_BASE  = 16,
  parameter int DISP_STEP  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         mode,
  input  logic [UADDR_W-1:0] target,
  input  logic               zflag,
  input  logic [UCNT_W-1:0]  ucount,
  input  logic [OPC_W-1:0]   opcode,
  output logic [UADDR_W-1:0] upc,
  output logic [UADDR_W-1:0] next_upc,
  output logic               trap_pulse
);

  localparam logic [UADDR_W-1:0] FETCH_UA = UADDR_W'(FETCH_ADDR);
  localparam logic [UADDR_W-1:0] ONE_UA   = UADDR_W'(1);

  umode_e             mode_e;
  logic               take_target;
  logic [UADDR_W-1:0] skip_adv;
  logic [UADDR_W-1:0] dispatch_addr;
  logic               dispatch_undef;
  logic [UADDR_W-1:0] seq_addr;
  logic               trap_now;

  assign mode_e   = umode_e'(mode);
  assign seq_addr = upc + ONE_UA;
  assign trap_now = (mode_e == UM_TRAP);

  useq_cond #(.UCNT_W(UCNT_W)) u_cond (
    .mode        (mode),
    .zflag       (zflag),
    .ucount      (ucount),
    .take_target (take_target)
  );

  useq_skip #(.UADDR_W(UADDR_W), .UCNT_W(UCNT_W), .MAXV(MAXV)) u_skip (
    .ucount   (ucount),
    .skip_adv (skip_adv)
  );

  useq_dispatch #(
    .UADDR_W   (UADDR_W),
    .OPC_W     (OPC_W),
    .NUM_OPS   (NUM_OPS),
    .BASE      (DISP_BASE),
    .STRIDE    (DISP_STEP),
    .TRAP_ADDR (TRAP_ADDR)
  ) u_dispatch (
    .opcode         (opcode),
    .dispatch_addr  (dispatch_addr),
    .dispatch_undef (dispatch_undef)
  );

  always_comb begin
    case (mode_e)
      UM_JZ0, UM_JZ1, UM_JU0: next_upc = take_target ? target : seq_addr;
      UM_SKIP:                next_upc = upc + skip_adv;
      UM_DISPATCH:            next_upc = dispatch_addr;
      UM_TRAP:                next_upc = FETCH_UA;
      default:                next_upc = seq_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc        <= FETCH_UA;
      trap_pulse <= 1'b0;
    end else begin
      upc        <= next_upc;
      trap_pulse <= trap_now;
    end
  end

endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int UADDR_W    = 8,
  parameter int OPC_W      = 5,
  parameter int UCNT_W     = 3,
  parameter int MAXV       = 4,
  parameter int FETCH_ADDR = 0,
  parameter int TRAP_ADDR  = 248
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         mode,
  input logic [UADDR_W-1:0] target,
  input logic               zflag,
  input logic [UCNT_W-1:0]  ucount,
  input logic [OPC_W-1:0]   opcode,
  input logic [UADDR_W-1:0] upc,
  input logic [UADDR_W-1:0] next_upc,
  input logic               trap_pulse,
  input logic               take_target,
  input logic               dispatch_undef
);

  localparam logic [UADDR_W-1:0] ONE_UA  = UADDR_W'(1);
  localparam logic [UADDR_W-1:0] FULL_UA = UADDR_W'(MAXV + 1);

  assert_reset_fetch_R1: assert property (@(posedge clk)
    !rst_n |=> (upc == UADDR_W'(FETCH_ADDR) && !trap_pulse));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode == 3'd7) |=> upc == $past(upc) + ONE_UA);

  assert_jz0_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && !zflag) |=> upc == $past(target));

  assert_jz0_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && zflag) |=> upc == $past(upc) + ONE_UA);

  assert_jz1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |=> upc == ($past(zflag) ? $past(target) : $past(upc) + ONE_UA));

  assert_ju0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && ucount == '0) |=> upc == $past(target));

  assert_cond_only_in_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode >= 3'd4) |-> !take_target);

  assert_skip_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && ucount == '0) |=> upc == $past(upc) + FULL_UA);

  assert_skip_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && int'(ucount) >= MAXV) |=> upc == $past(upc) + ONE_UA);

  assert_undef_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && dispatch_undef) |=> upc == UADDR_W'(TRAP_ADDR));

  assert_trap_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd6) |=> (trap_pulse && upc == UADDR_W'(FETCH_ADDR)));

  assert_trap_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd6) |=> !trap_pulse);

  assert_preview_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> upc == $past(next_upc));

endmodule

bind useq_sequencer useq_sequencer_chk #(
  .UADDR_W    (UADDR_W),
  .OPC_W      (OPC_W),
  .UCNT_W     (UCNT_W),
  .MAXV       (MAXV),
  .FETCH_ADDR (FETCH_ADDR),
  .TRAP_ADDR  (TRAP_ADDR)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode           (mode),
  .target         (target),
  .zflag          (zflag),
  .ucount         (ucount),
  .opcode         (opcode),
  .upc            (upc),
  .next_upc       (next_upc),
  .trap_pulse     (trap_pulse),
  .take_target    (take_target),
  .dispatch_undef (dispatch_undef)
);

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [7:0] target = 8'd0;
  logic       zflag = 1'b0;
  logic [2:0] ucount = 3'd0;
  logic [4:0] opcode = 5'd0;
  logic [7:0] upc;
  logic [7:0] next_upc;
  logic       trap_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] exp_upc = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_sequencer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .target     (target),
    .zflag      (zflag),
    .ucount     (ucount),
    .opcode     (opcode),
    .upc        (upc),
    .next_upc   (next_upc),
    .trap_pulse (trap_pulse)
  );

  function automatic logic [7:0] model_next(input logic [7:0] cur, input logic [2:0] m,
                                            input logic z, input logic [2:0] u,
                                            input logic [4:0] op, input logic [7:0] tgt);
    int unused_steps;
    case (m)
      3'd1: return z ? cur + 8'd1 : tgt;
      3'd2: return z ? tgt : cur + 8'd1;
      3'd3: return (u == 3'd0) ? tgt : cur + 8'd1;
      3'd4: begin
        unused_steps = (u >= 3'd4) ? 0 : 4 - int'(u);
        return cur + 8'd1 + 8'(unused_steps);
      end
      3'd5: return (op >= 5'd24) ? 8'd248 : 8'(16 + 8 * int'(op));
      3'd6: return 8'd0;
      default: return cur + 8'd1;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] m, input logic [4:0] op);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return (op >= 5'd24) ? "R8" : "R7";
      3'd6: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one microword cycle: drive away from the edge, check the preview, then the register
  task automatic cycle(input logic [2:0] m, input logic z, input logic [2:0] u,
                       input logic [4:0] op, input logic [7:0] tgt, input bit rst);
    logic [7:0] nxt;
    @(negedge clk);
    mode = m; zflag = z; ucount = u; opcode = op; target = tgt; rst_n = ~rst;
    nxt = model_next(exp_upc, m, z, u, op, tgt);
    #1;
    if (!rst) check("R10", "next_upc", next_upc, nxt);
    @(posedge clk);
    #1;
    if (rst) begin
      exp_upc = 8'd0;
      check("R1", "upc in reset", upc, 0);
      check("R1", "trap_pulse in reset", trap_pulse, 0);
    end else begin
      exp_upc = nxt;
      check(tag_of(m, op), "upc", upc, exp_upc);
      check("R9", "trap_pulse", trap_pulse, (m == 3'd6));
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state, also seen one edge after release
    cycle(3'd5, 1'b1, 3'd1, 5'd3, 8'd77, 1'b1);
    cycle(3'd6, 1'b0, 3'd0, 5'd0, 8'd0, 1'b1);
    cycle(3'd0, 1'b0, 3'd0, 5'd0, 8'd0, 1'b0);   // R2: 0 -> 1

    // R3/R4/R5 taken and not taken
    cycle(3'd1, 1'b0, 3'd5, 5'd9, 8'd40, 1'b0);
    cycle(3'd1, 1'b1, 3'd0, 5'd9, 8'd90, 1'b0);
    cycle(3'd2, 1'b1, 3'd5, 5'd9, 8'd60, 1'b0);
    cycle(3'd2, 1'b0, 3'd0, 5'd9, 8'd10, 1'b0);
    cycle(3'd3, 1'b1, 3'd0, 5'd9, 8'd100, 1'b0);
    cycle(3'd3, 1'b0, 3'd3, 5'd9, 8'd7, 1'b0);

    // R6: full, partial, none and saturated skips
    cycle(3'd4, 1'b0, 3'd0, 5'd0, 8'd0, 1'b0);
    cycle(3'd4, 1'b0, 3'd2, 5'd0, 8'd0, 1'b0);
    cycle(3'd4, 1'b0, 3'd4, 5'd0, 8'd0, 1'b0);
    cycle(3'd4, 1'b1, 3'd7, 5'd0, 8'd0, 1'b0);

    // R7/R8: dispatch boundaries
    cycle(3'd5, 1'b0, 3'd0, 5'd0, 8'd0, 1'b0);
    cycle(3'd5, 1'b0, 3'd0, 5'd23, 8'd0, 1'b0);
    cycle(3'd5, 1'b0, 3'd0, 5'd24, 8'd0, 1'b0);
    cycle(3'd5, 1'b0, 3'd0, 5'd31, 8'd0, 1'b0);

    // R9: trap then non-trap, pulse lasts one cycle
    cycle(3'd6, 1'b1, 3'd2, 5'd4, 8'd33, 1'b0);
    cycle(3'd0, 1'b0, 3'd0, 5'd0, 8'd0, 1'b0);
    cycle(3'd6, 1'b0, 3'd0, 5'd0, 8'd0, 1'b0);
    cycle(3'd6, 1'b0, 3'd0, 5'd0, 8'd0, 1'b0);
    cycle(3'd7, 1'b0, 3'd0, 5'd0, 8'd0, 1'b0);

    // R2: wrap at the top of the address space, reserved code steps too
    cycle(3'd1, 1'b0, 3'd0, 5'd0, 8'd255, 1'b0);
    cycle(3'd0, 1'b1, 3'd6, 5'd17, 8'd12, 1'b0);
    cycle(3'd2, 1'b1, 3'd0, 5'd0, 8'd254, 1'b0);
    cycle(3'd7, 1'b0, 3'd0, 5'd0, 8'd0, 1'b0);
    cycle(3'd4, 1'b0, 3'd1, 5'd0, 8'd0, 1'b0);

    // random microwords, with an occasional reset in the middle
    for (int i = 0; i < 1500; i++) begin
      cycle(3'($urandom_range(0, 7)), 1'($urandom), 3'($urandom_range(0, 7)),
            5'($urandom_range(0, 31)), 8'($urandom_range(0, 255)),
            ($urandom_range(0, 99) == 0));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule